// File: doc/BRIEF.md
# First-Level Miss Slot Pool

This block keeps track of first-level data cache misses that are still waiting for their line to arrive from the next level. It has a fixed pool of ten slots. Any request that missed the first-level cache takes a slot: a cacheable demand load, an uncached load, a store, or a software prefetch of any hint level. The slot records the 64-byte line address and the request kind until the fill for that slot returns. The fill then releases the slot. A request to a line that already has a pending slot joins that slot, so no second outbound miss is sent.

Two request ports are presented each cycle. A request that is accepted either gets a fresh slot, and the matching lane of the outbound miss port fires, or it merges into an existing slot. When no slot is available the request is stalled, never dropped. The requester keeps it asserted until it is accepted. A running count records each request, in each cycle, that wanted a slot and found none. In a cycle where both ports stall the count rises by two, so it can grow faster than the cycle count. A fill names its slot by index. In the same cycle the block reports the line address and kind held in that slot.

Top module: `miss_slot_pool`

## Requirements
- R1: After reset every slot is free, `poolFull` is 0, `rejectCount` is 0, and with no request valid no lane of `reqAccept` or `missValid` is set.
- R2: A request that needs a new slot is given the lowest-index free slot. In the same cycle its `missValid` lane is 1, with `missSlot` equal to that index and `missAddr` equal to the request address with its low 6 bits cleared.
- R3: All four kind codes take slots the same way: 0 cacheable load, 1 store, 2 software prefetch, 3 uncached load. The code is passed on `missKind` and is returned on `doneKind` when the slot's fill arrives, together with the line address on `doneAddr`.
- R4: At most 10 slots are pending. `poolFull` is 1 exactly when all 10 are pending.
- R5: A request that finds no slot has `reqAccept` 0 and `reqStall` 1, and sends no miss. It is accepted in the first cycle a slot is available while it is still held. This applies to prefetches as much as to loads.
- R6: Both ports may obtain new slots in one cycle, and they get distinct slots. When only one slot is free, port 0 gets it and port 1 stalls.
- R7: `rejectCount` rises at each clock edge by the number of ports stalled in the cycle before it.
- R8: A request whose line matches a pending slot is accepted with `reqSlot` naming that slot and sends no miss. This also holds when the pool is full.
- R9: When both ports present the same new line in one cycle, port 0 takes a slot and sends the miss. Port 1 is accepted into that same slot without a miss.
- R10: A fill (`fillValid`, `fillSlot`) frees its slot at the next edge. The freed slot cannot be allocated or merged into in the fill cycle itself, but can be used from the next cycle on.
- R11: Two addresses in the same 64-byte line count as the same line. An address in the next line counts as a different line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 2 | Per-port request valid, held while stalled |
| reqAddr | input | 2x40 | Per-port byte address |
| reqKind | input | 2x2 | Per-port request kind code |
| reqAccept | output | 2 | Request taken (new slot or merge) |
| reqStall | output | 2 | Request valid but no slot available |
| reqSlot | output | 2x4 | Slot index given to an accepted request |
| missValid | output | 2 | Outbound miss issued for this port |
| missAddr | output | 2x40 | Line-aligned address of the outbound miss |
| missSlot | output | 2x4 | Slot index of the outbound miss |
| missKind | output | 2x2 | Kind code of the outbound miss |
| fillValid | input | 1 | Fill returned for a slot |
| fillSlot | input | 4 | Index of the slot being filled |
| doneAddr | output | 40 | Line address held in the slot being filled |
| doneKind | output | 2 | Kind code held in the slot being filled |
| poolFull | output | 1 | All slots pending |
| rejectCount | output | 16 | Count of stalled request-cycles |

## Verification
The assertions assume that the next level only returns fills for slots that are pending: a fill names a busy slot, each slot is filled once, and the fill index is always below 10. The stimulus keeps to this by filling only slots that it allocated earlier in the same scenario. It never fills a slot twice without reallocating it in between, and it clears `fillValid` in every cycle that should have no fill. Stalled requests are held unchanged until they are accepted, which is the hand-over the requesters are expected to follow.

// File: rtl/mfb_pkg.sv
package mfb_pkg;
  localparam int unsigned POOL_N = 10;
  localparam int unsigned REQ_N  = 2;
  localparam int unsigned SLOT_W = $clog2(POOL_N);
  localparam int unsigned KIND_W = 2;
  localparam int unsigned INC_W  = $clog2(REQ_N + 1);

  typedef enum logic [KIND_W-1:0] {
    KIND_LOAD     = 2'd0,
    KIND_STORE    = 2'd1,
    KIND_PREFETCH = 2'd2,
    KIND_UC_LOAD  = 2'd3
  } reqKind_e;

  typedef struct packed {
    logic [REQ_N-1:0]             alloc;
    logic [REQ_N-1:0][SLOT_W-1:0] allocSlot;
    logic                         free;
    logic [SLOT_W-1:0]            freeSlot;
    logic [INC_W-1:0]             rejectInc;
  } strobe_t;

  function automatic logic [SLOT_W-1:0] lowestSet(input logic [POOL_N-1:0] vec);
    logic [SLOT_W-1:0] idx;
    idx = '0;
    for (int i = POOL_N - 1; i >= 0; i--) begin
      if (vec[i]) idx = SLOT_W'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/mfb_datapath.sv
module mfb_datapath
  import mfb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W    = ADDR_W - OFF_W
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          stb,
  input  logic [REQ_N-1:0][LINE_W-1:0]     reqLine,
  input  logic [REQ_N-1:0][KIND_W-1:0]     reqKind,
  input  logic [SLOT_W-1:0]                readSlot,
  output logic [POOL_N-1:0]                busy,
  output logic [REQ_N-1:0][POOL_N-1:0]     lineHit,
  output logic [REQ_N-1:0][REQ_N-1:0]      peerEq,
  output logic [LINE_W-1:0]                readLine,
  output logic [KIND_W-1:0]                readKind,
  output logic [CNT_W-1:0]                 rejectCount
);
  logic [LINE_W-1:0] lineTab [POOL_N];
  logic [KIND_W-1:0] kindTab [POOL_N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= '0;
      rejectCount <= '0;
    end else begin
      if (stb.free) busy[stb.freeSlot] <= 1'b0;
      for (int p = 0; p < REQ_N; p++) begin
        if (stb.alloc[p]) busy[stb.allocSlot[p]] <= 1'b1;
      end
      rejectCount <= rejectCount + CNT_W'(stb.rejectInc);
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < REQ_N; p++) begin
      if (stb.alloc[p]) begin
        lineTab[stb.allocSlot[p]] <= reqLine[p];
        kindTab[stb.allocSlot[p]] <= reqKind[p];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < REQ_N; p++) begin
      for (int e = 0; e < POOL_N; e++) begin
        lineHit[p][e] = busy[e] && (lineTab[e] == reqLine[p]);
      end
      for (int q = 0; q < REQ_N; q++) begin
        peerEq[p][q] = (reqLine[p] == reqLine[q]);
      end
    end
  end

  assign readLine = lineTab[readSlot];
  assign readKind = kindTab[readSlot];

  // R10
  fill_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.free |-> busy[stb.freeSlot]);

  // R10
  free_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.free |=> !busy[$past(stb.freeSlot)]);
endmodule

// File: rtl/mfb_control.sv
module mfb_control
  import mfb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [REQ_N-1:0]              reqValid,
  input  logic [REQ_N-1:0][POOL_N-1:0]  lineHit,
  input  logic [REQ_N-1:0][REQ_N-1:0]   peerEq,
  input  logic [POOL_N-1:0]             busy,
  input  logic                          fillValid,
  input  logic [SLOT_W-1:0]             fillSlot,
  output strobe_t                       stb,
  output logic [REQ_N-1:0]              reqAccept,
  output logic [REQ_N-1:0][SLOT_W-1:0]  reqSlot
);
  always_comb begin
    logic [POOL_N-1:0] avail;
    logic [POOL_N-1:0] fillMask;
    logic [POOL_N-1:0] hitM;
    logic              found;
    stb       = '0;
    reqAccept = '0;
    reqSlot   = '0;
    avail     = ~busy;
    fillMask  = fillValid ? (POOL_N'(1) << fillSlot) : '0;
    stb.free     = fillValid;
    stb.freeSlot = fillSlot;
    for (int p = 0; p < REQ_N; p++) begin
      hitM  = lineHit[p] & ~fillMask;
      found = 1'b0;
      if (reqValid[p]) begin
        if (|hitM) begin
          found      = 1'b1;
          reqSlot[p] = lowestSet(hitM);
        end
        for (int q = 0; q < REQ_N; q++) begin
          if (q < p && !found && stb.alloc[q] && peerEq[p][q]) begin
            found      = 1'b1;
            reqSlot[p] = reqSlot[q];
          end
        end
        if (!found && |avail) begin
          found            = 1'b1;
          reqSlot[p]       = lowestSet(avail);
          stb.alloc[p]     = 1'b1;
          stb.allocSlot[p] = reqSlot[p];
          avail[reqSlot[p]] = 1'b0;
        end
      end
      reqAccept[p] = found;
    end
    stb.rejectInc = INC_W'($countones(reqValid & ~reqAccept));
  end

  for (genvar p = 0; p < REQ_N; p++) begin : g_chk
    // R2
    alloc_free_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.alloc[p] |-> !busy[stb.allocSlot[p]]);
  end

  // R6
  slot_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.alloc[0] && stb.alloc[1]) |-> (stb.allocSlot[0] != stb.allocSlot[1]));

  // R5
  stall_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid[0] && !reqAccept[0]) |-> (&busy));
endmodule

// File: rtl/miss_slot_pool.sv
module miss_slot_pool
  import mfb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 40,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W    = ADDR_W - OFF_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [REQ_N-1:0]              reqValid,
  input  logic [REQ_N-1:0][ADDR_W-1:0]  reqAddr,
  input  logic [REQ_N-1:0][KIND_W-1:0]  reqKind,
  output logic [REQ_N-1:0]              reqAccept,
  output logic [REQ_N-1:0]              reqStall,
  output logic [REQ_N-1:0][SLOT_W-1:0]  reqSlot,
  output logic [REQ_N-1:0]              missValid,
  output logic [REQ_N-1:0][ADDR_W-1:0]  missAddr,
  output logic [REQ_N-1:0][SLOT_W-1:0]  missSlot,
  output logic [REQ_N-1:0][KIND_W-1:0]  missKind,
  input  logic                          fillValid,
  input  logic [SLOT_W-1:0]             fillSlot,
  output logic [ADDR_W-1:0]             doneAddr,
  output logic [KIND_W-1:0]             doneKind,
  output logic                          poolFull,
  output logic [CNT_W-1:0]              rejectCount
);
  strobe_t                         stb;
  logic [REQ_N-1:0][LINE_W-1:0]    reqLine;
  logic [POOL_N-1:0]               busy;
  logic [REQ_N-1:0][POOL_N-1:0]    lineHit;
  logic [REQ_N-1:0][REQ_N-1:0]     peerEq;
  logic [LINE_W-1:0]               readLine;

  for (genvar p = 0; p < REQ_N; p++) begin : g_port
    assign reqLine[p]  = reqAddr[p][ADDR_W-1:OFF_W];
    assign missAddr[p] = {reqLine[p], {OFF_W{1'b0}}};
  end

  mfb_control u_ctrl (
    .clk, .rstN, .reqValid, .lineHit, .peerEq, .busy,
    .fillValid, .fillSlot, .stb, .reqAccept, .reqSlot
  );

  mfb_datapath #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CNT_W(CNT_W)) u_data (
    .clk, .rstN, .stb, .reqLine, .reqKind, .readSlot(fillSlot),
    .busy, .lineHit, .peerEq, .readLine, .readKind(doneKind), .rejectCount
  );

  assign reqStall  = reqValid & ~reqAccept;
  assign missValid = stb.alloc;
  assign missSlot  = reqSlot;
  assign missKind  = reqKind;
  assign doneAddr  = {readLine, {OFF_W{1'b0}}};
  assign poolFull  = &busy;

  // R7
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqStall == '0) |=> $stable(rejectCount));
endmodule

// File: tb/miss_slot_pool_test.sv
`timescale 1ns/100ps
module miss_slot_pool_test;
  localparam int ADDR_W = 40;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       reqValid = '0;
  logic [1:0][39:0] reqAddr = '0;
  logic [1:0][1:0]  reqKind = '0;
  logic [1:0]       reqAccept, reqStall, missValid;
  logic [1:0][3:0]  reqSlot, missSlot;
  logic [1:0][39:0] missAddr;
  logic [1:0][1:0]  missKind;
  logic             fillValid = 1'b0;
  logic [3:0]       fillSlot = '0;
  logic [39:0]      doneAddr;
  logic [1:0]       doneKind;
  logic             poolFull;
  logic [15:0]      rejectCount;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  miss_slot_pool uut (
    .clk, .rstN, .reqValid, .reqAddr, .reqKind, .reqAccept, .reqStall, .reqSlot,
    .missValid, .missAddr, .missSlot, .missKind, .fillValid, .fillSlot,
    .doneAddr, .doneKind, .poolFull, .rejectCount
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #0.5;
  endtask

  task automatic settle();
    #0.5;
  endtask

  task automatic idle();
    reqValid  = '0;
    fillValid = 1'b0;
  endtask

  task automatic drive(input int p, input logic [39:0] addr, input logic [1:0] kind);
    reqValid[p] = 1'b1;
    reqAddr[p]  = addr;
    reqKind[p]  = kind;
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    doReset();
    settle();
    check("R1 poolFull", 64'(poolFull), 0);
    check("R1 rejectCount", 64'(rejectCount), 0);
    check("R1 reqAccept", 64'(reqAccept), 0);
    check("R1 missValid", 64'(missValid), 0);
    tick();
  endtask

  task automatic t_alloc_kinds();
    doReset();
    for (int i = 0; i < 4; i++) begin
      drive(0, 40'h1000 + 40'(i * 64) + 40'h13, 2'(i));
      settle();
      check("R3 accept", 64'(reqAccept[0]), 1);
      check("R2 missValid", 64'(missValid[0]), 1);
      check("R2 missSlot", 64'(missSlot[0]), 64'(i));
      check("R2 missAddr", 64'(missAddr[0]), 64'h1000 + 64'(i * 64));
      check("R3 missKind", 64'(missKind[0]), 64'(i));
      tick();
    end
    idle();
    fillValid = 1'b1; fillSlot = 4'd2;
    settle();
    check("R3 doneAddr", 64'(doneAddr), 64'h1080);
    check("R3 doneKind", 64'(doneKind), 2);
    tick();
    idle();
    drive(0, 40'h5000, 2'd1);
    settle();
    check("R10 reuse slot", 64'(reqSlot[0]), 2);
    check("R2 lowest free", 64'(missValid[0]), 1);
    tick();
    idle();
  endtask

  task automatic t_merge();
    doReset();
    drive(0, 40'h2000, 2'd0);
    settle();
    check("R2 first slot", 64'(missSlot[0]), 0);
    tick();
    drive(0, 40'h203F, 2'd1);
    settle();
    check("R8 merge accept", 64'(reqAccept[0]), 1);
    check("R8 merge slot", 64'(reqSlot[0]), 0);
    check("R11 same line no miss", 64'(missValid[0]), 0);
    tick();
    drive(0, 40'h2040, 2'd0);
    settle();
    check("R11 next line miss", 64'(missValid[0]), 1);
    check("R11 next line slot", 64'(missSlot[0]), 1);
    tick();
    idle();
  endtask

  task automatic t_dual();
    doReset();
    drive(0, 40'h3000, 2'd0);
    drive(1, 40'h3100, 2'd2);
    settle();
    check("R6 both miss", 64'(missValid), 3);
    check("R6 slot p0", 64'(missSlot[0]), 0);
    check("R6 slot p1", 64'(missSlot[1]), 1);
    tick();
    drive(0, 40'h3208, 2'd0);
    drive(1, 40'h3230, 2'd1);
    settle();
    check("R9 accepts", 64'(reqAccept), 3);
    check("R9 one miss", 64'(missValid), 1);
    check("R9 p0 slot", 64'(reqSlot[0]), 2);
    check("R9 p1 slot", 64'(reqSlot[1]), 2);
    tick();
    idle();
  endtask

  task automatic t_full_stall();
    doReset();
    for (int j = 0; j < 5; j++) begin
      drive(0, 40'h10000 + 40'(2 * j * 64), 2'd0);
      drive(1, 40'h10000 + 40'((2 * j + 1) * 64), 2'd3);
      tick();
    end
    idle();
    settle();
    check("R4 poolFull", 64'(poolFull), 1);
    drive(0, 40'h20000, 2'd2);
    settle();
    check("R5 prefetch stalled accept", 64'(reqAccept[0]), 0);
    check("R5 prefetch stall flag", 64'(reqStall[0]), 1);
    check("R5 no miss", 64'(missValid), 0);
    tick();
    check("R7 count one", 64'(rejectCount), 1);
    drive(1, 40'h20400, 2'd0);
    tick();
    check("R7 count two per cycle", 64'(rejectCount), 3);
    reqValid[1] = 1'b0;
    fillValid = 1'b1; fillSlot = 4'd4;
    settle();
    check("R10 no reuse in fill cycle", 64'(reqAccept[0]), 0);
    tick();
    check("R7 count after fill cycle", 64'(rejectCount), 4);
    fillValid = 1'b0;
    settle();
    check("R4 not full after free", 64'(poolFull), 0);
    check("R5 held prefetch accepted", 64'(reqAccept[0]), 1);
    check("R5 held prefetch slot", 64'(missSlot[0]), 4);
    tick();
    check("R4 full again", 64'(poolFull), 1);
    idle();
    fillValid = 1'b1; fillSlot = 4'd7;
    tick();
    fillValid = 1'b0;
    drive(0, 40'h30000, 2'd0);
    drive(1, 40'h30040, 2'd1);
    settle();
    check("R6 port0 wins", 64'(reqAccept), 1);
    check("R6 port0 slot", 64'(reqSlot[0]), 7);
    tick();
    check("R7 count port1 stall", 64'(rejectCount), 5);
    idle();
    drive(0, 40'h100C4, 2'd1);
    settle();
    check("R8 merge when full", 64'(reqAccept[0]), 1);
    check("R8 merge slot full", 64'(reqSlot[0]), 3);
    tick();
    idle();
  endtask

  initial begin
    t_reset();
    t_alloc_kinds();
    t_merge();
    t_dual();
    t_full_stall();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule